// File: doc/BRIEF.md
# Fixed Off-Time Mixed-Decay Current Chopper

This block is the digital controller for one H-bridge that regulates winding current with a fixed off-time. It drives one diagonal of the bridge until an external current comparator reports that the trip level has been reached. It then runs a timed off-period that has three parts: a fast-decay stretch, an all-off gap, and a slow-decay stretch. After the off-period it drives again.

During both decay stretches the controller switches on the transistors that carry the recirculating current, which is synchronous rectification. It drops them as soon as a zero-current detector fires, so the current cannot reverse. The trip input is masked for a short window at the start of every drive interval.

All durations are counted in clock cycles. They are derived from a clock-frequency parameter and from time parameters given in nanoseconds.

The controller has six states:
- `ST_OFF`: all gates off.
- `ST_DRIVE`: one diagonal on.
- `ST_FAST`: fast decay.
- `ST_GAP`: all-off gap.
- `ST_SLOW`: slow decay.
- `ST_SWAP`: all-off gap before the opposite diagonal is driven.

The transitions are:
- **start**: `ST_OFF`→`ST_DRIVE`.
- **trip**: `ST_DRIVE`→`ST_FAST`.
- **fast_done**: `ST_FAST`→`ST_GAP`.
- **gap_done**: `ST_GAP`→`ST_SLOW`.
- **off_done**: `ST_SLOW`→`ST_DRIVE`.
- **reverse**: `ST_DRIVE`→`ST_SWAP`.
- **swap_done**: `ST_SWAP`→`ST_DRIVE`.
- **halt**: any state→`ST_OFF`.

Top module: `hbridge_chopper`

## Requirements
- R1: After reset all four gate outputs are 0, and the block stays in `ST_OFF` until `en`=1 and `fault`=0 are sampled together. On the cycle after that sample, `ST_DRIVE` begins.
- R2: In `ST_DRIVE`, the gate vector {hi_a,hi_b,lo_a,lo_b} is 1001 when the direction latched at drive entry is 1, and 0110 when it is 0.
- R3: `trip` is ignored for the first BLANK cycles of every drive interval. When `trip` is held high, drive therefore lasts BLANK+1 cycles. A trip sampled after the window ends drive on the next cycle.
- R4: The off-time begins with FAST cycles of fast decay. Gates show the opposite diagonal: 0110 for direction 1, 1001 for direction 0.
- R5: After fast decay come DEAD cycles with all gates 0.
- R6: Slow decay fills the rest of the off-time: OFF−FAST−DEAD cycles with vector 0011. Drive then restarts with a fresh blanking window.
- R7: A `zero_det` sampled high during the off-time turns all gates off from the next cycle until the off-time ends. The latch clears when the next off-time starts.
- R8: If `phase` differs from the latched direction during drive, the block spends DEAD cycles with all gates 0 and then drives the new diagonal. This takes priority over a trip sampled in the same cycle.
- R9: A change of `phase` during the off-time does not alter the decay pattern. It takes effect at the next drive entry.
- R10: A sample of `fault`=1 or `en`=0 forces all gates to 0 from the next cycle while it lasts. On release, drive restarts with fresh blanking.
- R11: hi_a and lo_a are never 1 together, and hi_b and lo_b are never 1 together.
- R12: Cycle counts are computed as follows, with K = CLK_HZ/1000:
  - OFF = ⌊K·OFF_NS/10⁶⌋
  - FAST = ⌊OFF·FAST_PERMILLE/1000⌋
  - DEAD = ⌊K·DEAD_NS/10⁶⌋
  - BLANK = ⌊K·BLANK_NS/10⁶⌋

  With the defaults at 50 MHz these give 1500, 451, 30 and 50 cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| en | input | 1 | Run enable |
| fault | input | 1 | Fault: over-temperature, low gate supply or undervoltage |
| phase | input | 1 | Requested current direction |
| trip | input | 1 | Current-trip comparator output |
| zero_det | input | 1 | Zero-current detect |
| gate_hi_a | output | 1 | High-side gate, leg A |
| gate_hi_b | output | 1 | High-side gate, leg B |
| gate_lo_a | output | 1 | Low-side gate, leg A |
| gate_lo_b | output | 1 | Low-side gate, leg B |

## Verification
The bench builds the block with CLK_HZ = 10 MHz, which gives OFF=300, FAST=90, DEAD=6 and BLANK=10 cycles. At these values the off-period splits into the same proportions as the default, but is short enough that hundreds of complete chopping periods fit in one run. Random trip, zero-detect, phase, fault and enable activity can therefore reach every transition, including mid-gap faults and phase flips on the exact cycle a trip is accepted. Directed runs measure each window length exactly.

// File: rtl/chop_pkg.sv
package chop_pkg;
    typedef enum logic [2:0] {
        ST_OFF,
        ST_DRIVE,
        ST_FAST,
        ST_GAP,
        ST_SLOW,
        ST_SWAP
    } chop_state_e;

    typedef struct packed {
        logic hi_a;
        logic hi_b;
        logic lo_a;
        logic lo_b;
    } gate_t;
endpackage

// File: rtl/chop_timer.sv
// Saturating elapsed-cycle counter, restarted by clr.
module chop_timer #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr,
    output logic [W-1:0] elapsed
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            elapsed <= '0;
        end else if (clr) begin
            elapsed <= '0;
        end else if (elapsed != {W{1'b1}}) begin
            elapsed <= elapsed + 1'b1;
        end
    end
endmodule

// File: rtl/chop_gate_map.sv
// Decodes controller state into the four bridge gate enables.
module chop_gate_map
    import chop_pkg::*;
(
    input  chop_state_e st,
    input  logic        dir,
    input  logic        zc,
    output gate_t       g
);
    always_comb begin
        g = '0;
        unique case (st)
            ST_DRIVE: begin
                if (dir) begin
                    g.hi_a = 1'b1;
                    g.lo_b = 1'b1;
                end else begin
                    g.hi_b = 1'b1;
                    g.lo_a = 1'b1;
                end
            end
            ST_FAST: begin
                if (!zc) begin
                    if (dir) begin
                        g.hi_b = 1'b1;
                        g.lo_a = 1'b1;
                    end else begin
                        g.hi_a = 1'b1;
                        g.lo_b = 1'b1;
                    end
                end
            end
            ST_SLOW: begin
                if (!zc) begin
                    g.lo_a = 1'b1;
                    g.lo_b = 1'b1;
                end
            end
            default: g = '0;
        endcase
    end
endmodule

// File: rtl/hbridge_chopper.sv
module hbridge_chopper
    import chop_pkg::*;
#(
    parameter int CLK_HZ        = 50_000_000,
    parameter int OFF_NS        = 30_000,
    parameter int FAST_PERMILLE = 301,
    parameter int DEAD_NS       = 600,
    parameter int BLANK_NS      = 1_000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic en,
    input  logic fault,
    input  logic phase,
    input  logic trip,
    input  logic zero_det,
    output logic gate_hi_a,
    output logic gate_hi_b,
    output logic gate_lo_a,
    output logic gate_lo_b
);
    localparam longint KHZ       = longint'(CLK_HZ) / 1000;
    localparam int     OFF_CYC   = int'(KHZ * longint'(OFF_NS) / 1_000_000);
    localparam int     FAST_CYC  = int'(longint'(OFF_CYC) * longint'(FAST_PERMILLE) / 1000);
    localparam int     DEAD_CYC  = int'(KHZ * longint'(DEAD_NS) / 1_000_000);
    localparam int     BLANK_CYC = int'(KHZ * longint'(BLANK_NS) / 1_000_000);
    localparam int     OW        = $clog2(OFF_CYC + 1);
    localparam int     BW        = $clog2(BLANK_CYC + 1);
    localparam logic [OW-1:0] FAST_END  = OW'(FAST_CYC - 1);
    localparam logic [OW-1:0] GAP_END   = OW'(FAST_CYC + DEAD_CYC - 1);
    localparam logic [OW-1:0] OFF_END   = OW'(OFF_CYC - 1);
    localparam logic [OW-1:0] SWAP_END  = OW'(DEAD_CYC - 1);
    localparam logic [BW-1:0] BLANK_LIM = BW'(BLANK_CYC);

    chop_state_e   st_q, st_d;
    logic          dir_q, zc_q;
    logic [OW-1:0] off_el;
    logic [BW-1:0] blank_el;
    logic          run_ok, entering, off_clr, blank_clr;
    gate_t         g;

    assign run_ok    = en & ~fault;
    assign entering  = (st_d != st_q);
    assign off_clr   = entering && (st_d == ST_FAST || st_d == ST_SWAP);
    assign blank_clr = entering && (st_d == ST_DRIVE);

    chop_timer #(.W(OW)) u_off_tmr (
        .clk(clk), .rst_n(rst_n), .clr(off_clr), .elapsed(off_el)
    );

    chop_timer #(.W(BW)) u_blank_tmr (
        .clk(clk), .rst_n(rst_n), .clr(blank_clr), .elapsed(blank_el)
    );

    // Next-state logic
    always_comb begin
        st_d = st_q;
        if (!run_ok) begin
            st_d = ST_OFF;                              // halt
        end else begin
            unique case (st_q)
                ST_OFF:   st_d = ST_DRIVE;              // start
                ST_DRIVE: begin
                    if (phase != dir_q)
                        st_d = ST_SWAP;                 // reverse
                    else if (trip && blank_el >= BLANK_LIM)
                        st_d = ST_FAST;                 // trip
                end
                ST_FAST:  if (off_el == FAST_END) st_d = ST_GAP;    // fast_done
                ST_GAP:   if (off_el == GAP_END)  st_d = ST_SLOW;   // gap_done
                ST_SLOW:  if (off_el == OFF_END)  st_d = ST_DRIVE;  // off_done
                ST_SWAP:  if (off_el == SWAP_END) st_d = ST_DRIVE;  // swap_done
                default:  st_d = ST_OFF;
            endcase
        end
    end

    // State register with direction and zero-current latches
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q  <= ST_OFF;
            dir_q <= 1'b0;
            zc_q  <= 1'b0;
        end else begin
            st_q <= st_d;
            if (blank_clr) dir_q <= phase;
            if (entering && st_d == ST_FAST)
                zc_q <= 1'b0;
            else if (zero_det && (st_q inside {ST_FAST, ST_GAP, ST_SLOW}))
                zc_q <= 1'b1;
        end
    end

    // Output decode
    chop_gate_map u_gate_map (
        .st(st_q), .dir(dir_q), .zc(zc_q), .g(g)
    );

    assign gate_hi_a = g.hi_a;
    assign gate_hi_b = g.hi_b;
    assign gate_lo_a = g.lo_a;
    assign gate_lo_b = g.lo_b;

    // Assertions
    p_no_shoot_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !(gate_hi_a && gate_lo_a) && !(gate_hi_b && gate_lo_b));

    p_fault_off_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (!en || fault) |=> ({gate_hi_a, gate_hi_b, gate_lo_a, gate_lo_b} == 4'b0000));

    p_blank_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_DRIVE && blank_el < BLANK_LIM && run_ok && phase == dir_q)
        |=> st_q == ST_DRIVE);

    p_fast_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_FAST && off_el != FAST_END && run_ok) |=> st_q == ST_FAST);

    p_gap_quiet_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_GAP) |-> ({gate_hi_a, gate_hi_b, gate_lo_a, gate_lo_b} == 4'b0000));

    p_zc_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (zc_q && (st_q == ST_FAST || st_q == ST_SLOW))
        |-> ({gate_hi_a, gate_hi_b, gate_lo_a, gate_lo_b} == 4'b0000));

    p_swap_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_DRIVE && run_ok && phase != dir_q)
        |=> ({gate_hi_a, gate_hi_b, gate_lo_a, gate_lo_b} == 4'b0000));
endmodule

// File: tb/hbridge_chopper_bench.sv
module hbridge_chopper_bench;
    localparam int CLK_HZ = 10_000_000;
    localparam int K  = CLK_HZ / 1000;
    localparam int O  = K * 30_000 / 1_000_000;   // R12
    localparam int F  = O * 301 / 1000;
    localparam int D  = K * 600 / 1_000_000;
    localparam int B  = K * 1_000 / 1_000_000;

    localparam int M_OFF = 0, M_DRV = 1, M_FST = 2, M_GAP = 3, M_SLW = 4, M_SWP = 5;

    logic clk = 1'b0, rst_n = 1'b0;
    logic en = 1'b0, fault = 1'b0, phase = 1'b1, trip = 1'b0, zero_det = 1'b0;
    logic gate_hi_a, gate_hi_b, gate_lo_a, gate_lo_b;
    logic [3:0] gates;

    int n_chk = 0, n_fail = 0, wd = 0;
    int m_st = M_OFF, m_off = 0, m_blk = 0, nst = M_OFF;
    bit m_dir = 1'b0, m_zc = 1'b0;

    always #4 clk = ~clk;

    hbridge_chopper #(.CLK_HZ(CLK_HZ)) u_hbridge_chopper (
        .clk(clk), .rst_n(rst_n), .en(en), .fault(fault), .phase(phase),
        .trip(trip), .zero_det(zero_det),
        .gate_hi_a(gate_hi_a), .gate_hi_b(gate_hi_b),
        .gate_lo_a(gate_lo_a), .gate_lo_b(gate_lo_b)
    );

    assign gates = {gate_hi_a, gate_hi_b, gate_lo_a, gate_lo_b};

    // Reference model built from the requirements
    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_st = M_OFF; m_off = 0; m_blk = 0; m_dir = 1'b0; m_zc = 1'b0;
        end else begin
            if (!en || fault) nst = M_OFF;
            else case (m_st)
                M_OFF: nst = M_DRV;
                M_DRV: nst = (phase != m_dir) ? M_SWP : ((trip && m_blk >= B) ? M_FST : M_DRV);
                M_FST: nst = (m_off == F - 1) ? M_GAP : M_FST;
                M_GAP: nst = (m_off == F + D - 1) ? M_SLW : M_GAP;
                M_SLW: nst = (m_off == O - 1) ? M_DRV : M_SLW;
                M_SWP: nst = (m_off == D - 1) ? M_DRV : M_SWP;
                default: nst = M_OFF;
            endcase
            if (nst != m_st && nst == M_FST) m_zc = 1'b0;
            else if (zero_det && (m_st == M_FST || m_st == M_GAP || m_st == M_SLW)) m_zc = 1'b1;
            if (nst != m_st && (nst == M_FST || nst == M_SWP)) m_off = 0;
            else if (m_off < 100000) m_off++;
            if (nst != m_st && nst == M_DRV) begin m_blk = 0; m_dir = phase; end
            else if (m_blk < 100000) m_blk++;
            m_st = nst;
        end
    end

    function automatic logic [3:0] exp_gates(int st, bit dir, bit zc);
        case (st)
            M_DRV: return dir ? 4'b1001 : 4'b0110;
            M_FST: return zc ? 4'b0000 : (dir ? 4'b0110 : 4'b1001);
            M_SLW: return zc ? 4'b0000 : 4'b0011;
            default: return 4'b0000;
        endcase
    endfunction

    function automatic string req_of(int st, bit zc);
        if (zc && (st == M_FST || st == M_SLW)) return "R7";
        case (st)
            M_DRV: return "R2";
            M_FST: return "R4";
            M_GAP: return "R5";
            M_SLW: return "R6";
            M_SWP: return "R8";
            default: return "R1";
        endcase
    endfunction

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic step();
        @(negedge clk);
        chk(gates == exp_gates(m_st, m_dir, m_zc), req_of(m_st, m_zc),
            gates, exp_gates(m_st, m_dir, m_zc));
        chk(!(gate_hi_a && gate_lo_a) && !(gate_hi_b && gate_lo_b), "R11", gates, 0);
    endtask

    task automatic count_run(input logic [3:0] pat, output int n);
        n = 0;
        while (gates == pat && n < 2000) begin
            n++;
            step();
        end
    endtask

    always @(posedge clk) begin
        wd++;
        if (wd > 150_000) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog expired actual=%0d expected<150000", wd);
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        int n;
        void'($urandom(32'd1234));
        // R1: reset state
        repeat (3) step();
        chk(gates == 4'b0000, "R1", gates, 0);
        @(negedge clk) rst_n = 1'b1;
        step();
        chk(gates == 4'b0000, "R1", gates, 0);

        // R3, R4, R5, R6, R12: window lengths with trip held high
        phase = 1'b1; trip = 1'b1; en = 1'b1;
        step();
        chk(gates == 4'b1001, "R2", gates, 4'b1001);
        count_run(4'b1001, n); chk(n == B + 1, "R3", n, B + 1);
        count_run(4'b0110, n); chk(n == F, "R12", n, F);
        chk(n == 90, "R4", n, 90);
        count_run(4'b0000, n); chk(n == D, "R5", n, D);
        count_run(4'b0011, n); chk(n == O - F - D, "R6", n, O - F - D);
        chk(gates == 4'b1001, "R6", gates, 4'b1001);
        count_run(4'b1001, n); chk(n == B + 1, "R3", n, B + 1);

        // R7: zero detect mid fast decay
        repeat (4) step();
        zero_det = 1'b1;
        step();
        chk(gates == 4'b0000, "R7", gates, 0);
        zero_det = 1'b0;
        count_run(4'b0000, n); chk(n == O - 5, "R7", n, O - 5);
        chk(gates == 4'b1001, "R7", gates, 4'b1001);

        // R9: phase flip during off-time
        count_run(4'b1001, n);
        phase = 1'b0;
        step();
        chk(gates == 4'b0110, "R9", gates, 4'b0110);
        count_run(4'b0110, n);
        count_run(4'b0000, n);
        count_run(4'b0011, n);
        chk(gates == 4'b0110, "R9", gates, 4'b0110);

        // R8: phase flip together with an accepted trip
        trip = 1'b0;
        repeat (12) step();
        trip = 1'b1; phase = 1'b1;
        step();
        chk(gates == 4'b0000, "R8", gates, 0);
        count_run(4'b0000, n); chk(n == D, "R8", n, D);
        chk(gates == 4'b1001, "R8", gates, 4'b1001);

        // R10: fault and enable
        fault = 1'b1;
        step();
        chk(gates == 4'b0000, "R10", gates, 0);
        repeat (20) step();
        chk(gates == 4'b0000, "R10", gates, 0);
        fault = 1'b0;
        step();
        chk(gates == 4'b1001, "R10", gates, 4'b1001);
        count_run(4'b1001, n); chk(n == B + 1, "R10", n, B + 1);
        en = 1'b0;
        step();
        chk(gates == 4'b0000, "R10", gates, 0);
        en = 1'b1;
        step();
        chk(gates == 4'b1001, "R10", gates, 4'b1001);

        // Constrained random activity against the model
        for (int i = 0; i < 30000; i++) begin
            trip     = ($urandom_range(0, 999) < 300);
            zero_det = ($urandom_range(0, 999) < 15);
            if ($urandom_range(0, 999) < 4) phase = ~phase;
            if (fault) fault = ($urandom_range(0, 9) != 0);
            else       fault = ($urandom_range(0, 1999) == 0);
            if (!en)   en = ($urandom_range(0, 9) == 0);
            else       en = ($urandom_range(0, 2999) != 0);
            step();
        end

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule